// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block collects up to 32 level-sensitive interrupt inputs from peripherals and forwards them to a small set of processor interrupt request lines. Software controls it through a 32-bit register window. The window holds an enable mask with one bit per source, a read-only view of the synchronized input levels, and four routing words. The routing words give every source its own 4-bit field, and that field picks the processor line the source drives. Each processor line is the OR of every source that is asserted, enabled and routed to it. The line stays high for as long as any such source stays high.

A helper register returns the number of the lowest-numbered source that is both asserted and enabled. A dispatch routine can therefore pick its next source with one read. Inputs pass through a synchronizer chain before they are used. The request lines are registered. Register writes take effect at the clock edge on which the write strobe is sampled. Reads are combinational from the address.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset the mask and all routing words read 0, every request line is low, and with all inputs low the helper register at 0x18 reads 0x8000_0000.
- R2: The word at byte offset 0x00 is read/write. Bit n set to 1 enables source n, and the value written reads back unchanged.
- R3: The word at 0x04 returns the input levels after SYNC_STAGES clock edges, whatever the mask holds. Writes to 0x04 change no register and no request line.
- R4: Routing fields are 4 bits wide. Source n owns bits [4*(n%8)+3 : 4*(n%8)] of the word at byte offset 0x14 - 4*(n/8): sources 0-7 sit at 0x14, 8-15 at 0x10, 16-23 at 0x0C and 24-31 at 0x08. Each routing word reads back as written.
- R5: A field value v from 1 to 7 sends the source to request line v. Value 0 and values 8 to 15 send it to no line, so line 0 is never asserted.
- R6: Request line k is high exactly when at least one source is asserted, enabled and routed to k. Several sources on one line are ORed, and the line stays high until the last of them drops.
- R7: Request lines are registered. A write to the mask or to a routing word changes them one clock edge after the write edge. A change on an input reaches them SYNC_STAGES+1 edges after it is applied.
- R8: The word at 0x18 is read-only. When some source is both asserted and enabled, bits [4:0] hold the lowest such source number and bits [31:5] are 0. When none is, it reads 0x8000_0000. Routing has no effect on this value.
- R9: Offset 0x1C and any address whose two low bits are not 00 read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC (32) | Level-sensitive peripheral interrupt inputs |
| wr_en | input | 1 | Write strobe, sampled at the rising clock edge |
| addr | input | ADDR_W (5) | Byte address, used for both reads and writes |
| wr_data | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Read data, a combinational function of addr |
| irq_o | output | NUM_LINES (8) | Registered processor interrupt request lines |

## Verification
A table of vectors drives single sources at the edges of the source range and of each routing word. It also drives two enabled sources on different lines, two sources where only one is enabled, and a source whose field holds 0, 9 or 15. These cases separate a wrong field position or word order from a wrong enable or a wrong line decode. Directed tests apply all inputs high with the mask clear. They also hold two sources on one line and release them one at a time, which tells a true OR of levels apart from tracking the last change. Writes to the status word, to an unmapped word and to a misaligned address check that nothing else moves. Exact-cycle checks after a mask write and after an input change tell registered, synchronized behaviour apart from a combinational path or a wrong synchronizer depth.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int ROUTE_W         = 4;
    localparam int FIELDS_PER_WORD = 8;
    localparam int MASK_IDX        = 0;
    localparam int STATUS_IDX      = 1;
    localparam int ROUTE_IDX       = 2;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.stage[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            sync_d.stage[s] = sync_q.stage[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q.stage[STAGES-1];
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int WIDX_W  = 3
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [WIDX_W-1:0]                      widx,
    input  logic [DATA_W-1:0]                      wr_data,
    output logic [NUM_SRC-1:0]                     mask_o,
    output logic [NUM_SRC/FIELDS_PER_WORD-1:0][DATA_W-1:0] route_o,
    output logic [NUM_SRC-1:0][ROUTE_W-1:0]        field_o
);
    localparam int NUM_RREG = NUM_SRC / FIELDS_PER_WORD;

    typedef struct packed {
        logic [NUM_SRC-1:0]               mask;
        logic [NUM_RREG-1:0][DATA_W-1:0]  route;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (int'(widx) == MASK_IDX) regs_d.mask = wr_data[NUM_SRC-1:0];
            for (int r = 0; r < NUM_RREG; r++) begin
                if (int'(widx) == ROUTE_IDX + r) regs_d.route[r] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign mask_o  = regs_q.mask;
    assign route_o = regs_q.route;

    // Reversed word order: lowest sources live in the highest routing word
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_field
        assign field_o[n] = regs_q.route[NUM_RREG-1-(n/FIELDS_PER_WORD)]
                                        [ROUTE_W*(n%FIELDS_PER_WORD) +: ROUTE_W];
    end

    a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && int'(widx) == MASK_IDX) |-> mask_o == $past(wr_data[NUM_SRC-1:0]));

    a_r3_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && int'(widx) == STATUS_IDX) |-> ($stable(mask_o) && $stable(route_o)));
endmodule

// File: rtl/irq_line_route.sv
module irq_line_route
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int NUM_LINES = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SRC-1:0]              level_i,
    input  logic [NUM_SRC-1:0]              mask_i,
    input  logic [NUM_SRC-1:0][ROUTE_W-1:0] field_i,
    output logic [NUM_LINES-1:0]            irq_o
);
    typedef struct packed {
        logic [NUM_LINES-1:0] irq;
    } line_t;

    line_t line_d, line_q;
    logic [NUM_LINES-1:0] hit;

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic [NUM_SRC-1:0] sel;
        always_comb begin
            for (int n = 0; n < NUM_SRC; n++) begin
                sel[n] = (field_i[n] == ROUTE_W'(l));
            end
        end
        // Field value 0 means "not routed", so line 0 never collects sources
        assign hit[l] = (l != 0) && (|(sel & level_i & mask_i));

        a_r6_line_has_source: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[l] |-> $past(|(level_i & mask_i)));
    end

    always_comb begin
        line_d     = line_q;
        line_d.irq = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign irq_o = line_q.irq;
endmodule

// File: rtl/irq_lowest.sv
module irq_lowest #(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic [DATA_W-1:0]  find_o
);
    localparam int IDX_W = $clog2(NUM_SRC);

    always_comb begin
        find_o = '0;
        find_o[DATA_W-1] = 1'b1;
        for (int n = NUM_SRC - 1; n >= 0; n--) begin
            if (pend_i[n]) begin
                find_o = '0;
                find_o[IDX_W-1:0] = IDX_W'(n);
            end
        end
    end

    always_comb begin
        if (!$isunknown(pend_i) && !find_o[DATA_W-1]) begin
            a_r8_find_lowest: assert (pend_i[find_o[IDX_W-1:0]] &&
                ((pend_i & ((NUM_SRC'(1) << find_o[IDX_W-1:0]) - NUM_SRC'(1))) == '0));
        end
    end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int NUM_LINES   = 8,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_i,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    output logic [NUM_LINES-1:0] irq_o
);
    localparam int NUM_RREG = NUM_SRC / FIELDS_PER_WORD;
    localparam int FIND_IDX = ROUTE_IDX + NUM_RREG;
    localparam int WIDX_W   = ADDR_W - 2;

    logic                            aligned;
    logic [WIDX_W-1:0]               widx;
    logic [NUM_SRC-1:0]              status_w;
    logic [NUM_SRC-1:0]              mask_w;
    logic [NUM_RREG-1:0][DATA_W-1:0] route_w;
    logic [NUM_SRC-1:0][ROUTE_W-1:0] field_w;
    logic [NUM_SRC-1:0]              pend_w;
    logic [DATA_W-1:0]               find_w;

    assign aligned = (addr[1:0] == 2'b00);
    assign widx    = addr[ADDR_W-1:2];
    assign pend_w  = status_w & mask_w;

    irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .async_i(src_i), .sync_o(status_w)
    );

    irq_regfile #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .WIDX_W(WIDX_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && aligned), .widx(widx),
        .wr_data(wr_data), .mask_o(mask_w), .route_o(route_w), .field_o(field_w)
    );

    irq_line_route #(.NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES)) i_lines (
        .clk(clk), .rst_n(rst_n), .level_i(status_w), .mask_i(mask_w),
        .field_i(field_w), .irq_o(irq_o)
    );

    irq_lowest #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) i_lowest (
        .pend_i(pend_w), .find_o(find_w)
    );

    always_comb begin
        rd_data = '0;
        if (aligned) begin
            if (int'(widx) == MASK_IDX)   rd_data = DATA_W'(mask_w);
            if (int'(widx) == STATUS_IDX) rd_data = DATA_W'(status_w);
            for (int r = 0; r < NUM_RREG; r++) begin
                if (int'(widx) == ROUTE_IDX + r) rd_data = route_w[r];
            end
            if (int'(widx) == FIND_IDX)   rd_data = find_w;
        end
    end

    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mask_w == '0) |-> irq_o == '0);

    a_r8_none_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w == '0) |-> find_w[DATA_W-1]);
endmodule

// File: tb/test_irq_route_ctrl.sv
module test_irq_route_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  irq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_route_ctrl i_irq_route_ctrl (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] mask;
        logic [31:0] r08;
        logic [31:0] r0c;
        logic [31:0] r10;
        logic [31:0] r14;
        logic [7:0]  irq;
        logic [31:0] find;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0001, 32'h0000_0001, 32'h0, 32'h0, 32'h0, 32'h0000_0003, 8'h08, 32'd0},
        '{32'h8000_0000, 32'h8000_0000, 32'h5000_0000, 32'h0, 32'h0, 32'h0, 8'h20, 32'd31},
        '{32'h0000_0110, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0000_0002, 32'h0002_0000, 8'h04, 32'd4},
        '{32'h0000_0110, 32'h0000_0100, 32'h0, 32'h0, 32'h0000_0002, 32'h0002_0000, 8'h04, 32'd8},
        '{32'h0000_0110, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0000_0009, 32'h0000_0000, 8'h00, 32'd4},
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h7777_7777, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 8'h00, 32'h8000_0000},
        '{32'h0001_0000, 32'hFFFF_FFFF, 32'h0, 32'h0000_0007, 32'h0, 32'h0, 8'h80, 32'd16},
        '{32'h0000_0003, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h0000_0041, 8'h12, 32'd0},
        '{32'h0000_0001, 32'h0000_0001, 32'h0, 32'h0, 32'h0, 32'h0000_000F, 8'h00, 32'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 irq after reset", {24'h0, irq_o}, 32'h0);
        rst_n = 1'b1;
        settle();
        bus_read(5'h00, v); check("R1 mask reset", v, 32'h0);
        bus_read(5'h08, v); check("R1 route 08 reset", v, 32'h0);
        bus_read(5'h14, v); check("R1 route 14 reset", v, 32'h0);
        bus_read(5'h18, v); check("R1 find reset", v, 32'h8000_0000);
        check("R1 irq idle", {24'h0, irq_o}, 32'h0);

        // Table walk: R2 R4 R5 R6 R8 R3
        for (int i = 0; i < NVEC; i++) begin
            bus_write(5'h00, VECS[i].mask);
            bus_write(5'h08, VECS[i].r08);
            bus_write(5'h0C, VECS[i].r0c);
            bus_write(5'h10, VECS[i].r10);
            bus_write(5'h14, VECS[i].r14);
            src_i = VECS[i].src;
            settle();
            check($sformatf("R5 R6 irq vec %0d", i), {24'h0, irq_o}, {24'h0, VECS[i].irq});
            bus_read(5'h18, v); check($sformatf("R8 find vec %0d", i), v, VECS[i].find);
            bus_read(5'h04, v); check($sformatf("R3 status vec %0d", i), v, VECS[i].src);
            bus_read(5'h00, v); check($sformatf("R2 mask readback vec %0d", i), v, VECS[i].mask);
            bus_read(5'h08, v); check($sformatf("R4 r08 readback vec %0d", i), v, VECS[i].r08);
            bus_read(5'h14, v); check($sformatf("R4 r14 readback vec %0d", i), v, VECS[i].r14);
        end

        // R3: write to status ignored
        bus_write(5'h00, 32'h0000_0001);
        bus_write(5'h14, 32'h0000_0001);
        src_i = 32'h0000_0001;
        settle();
        bus_write(5'h04, 32'hFFFF_FFFF);
        bus_read(5'h04, v); check("R3 status after write", v, 32'h0000_0001);
        bus_read(5'h00, v); check("R3 mask after status write", v, 32'h0000_0001);
        check("R3 irq after status write", {24'h0, irq_o}, 32'h2);

        // R9: unmapped and misaligned
        bus_write(5'h1C, 32'hDEAD_BEEF);
        bus_read(5'h1C, v); check("R9 unmapped read", v, 32'h0);
        bus_write(5'h01, 32'h0000_00F0);
        bus_read(5'h00, v); check("R9 mask after misaligned write", v, 32'h0000_0001);
        bus_read(5'h01, v); check("R9 misaligned read", v, 32'h0);
        bus_read(5'h14, v); check("R9 route after unmapped write", v, 32'h0000_0001);

        // R7: mask write latency
        bus_write(5'h00, 32'h0);
        settle();
        check("R7 irq off before write", {24'h0, irq_o}, 32'h0);
        bus_write(5'h00, 32'h0000_0001);
        check("R7 irq unchanged at write edge", {24'h0, irq_o}, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R7 irq one edge after write", {24'h0, irq_o}, 32'h2);
        // R7: input change latency
        src_i = 32'h0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        bus_read(5'h04, v); check("R7 status after two edges", v, 32'h0);
        check("R7 irq still high after two edges", {24'h0, irq_o}, 32'h2);
        @(posedge clk); @(negedge clk);
        check("R7 irq low after three edges", {24'h0, irq_o}, 32'h0);

        // R6: level hold with two sources on one line
        bus_write(5'h14, 32'h0000_0011);
        bus_write(5'h00, 32'h0000_0003);
        src_i = 32'h0000_0003;
        settle();
        check("R6 two sources one line", {24'h0, irq_o}, 32'h2);
        src_i = 32'h0000_0002;
        settle();
        check("R6 line held by remaining source", {24'h0, irq_o}, 32'h2);
        bus_read(5'h18, v); check("R8 find after drop", v, 32'd1);
        src_i = 32'h0;
        settle();
        check("R6 line drops with last source", {24'h0, irq_o}, 32'h0);
        bus_read(5'h18, v); check("R8 find none", v, 32'h8000_0000);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule